// File: doc/BRIEF.md
# Per-Thread Interrupt Priority Presenter

This block keeps the interrupt context of one hardware thread at one privilege ring. Event notifications and software "set pending" writes mark priorities in an 8-bit pending bitmap. The block derives the most favoured pending priority from that bitmap and compares it with the thread's current processor priority. When a pending priority beats the current one, the block sets an exception flag and raises a level interrupt line to the CPU.

Software takes the interrupt with an acknowledge operation. In one step the acknowledge adopts the pending priority as the new current priority, retires its pending bit and clears the flag. It also returns a 16-bit status word. A read port exposes the four context registers.

Top module: `prio_presenter`

## Requirements
- R1: A priority p in 0..7 sets pending-buffer bit (7 - p). Lower numbers are more favoured. A set-pending data byte above 7 sets no bit.
- R2: The pending-priority register holds the index of the most favoured pending priority, which is the count of leading zeros of the pending buffer. It reads 0xFF when the buffer is empty.
- R3: Reset is asynchronous and active low. After reset the pending buffer, the current priority and the status register are 0x00, the pending priority is 0xFF, and the interrupt output is low.
- R4: When the check runs and the pending priority is strictly below the current priority, status bit 7 (the exception flag) is set and irq_o rises one clock later. Equal values raise nothing.
- R5: The check runs after a notification, after a set-pending write and after a current-priority write. The current-priority write takes effect in the same cycle as its check. Re-posting a priority that is already pending still runs the check.
- R6: An acknowledge always lowers irq_o. If the exception flag was set, the acknowledge also copies the pending priority into the current priority, clears that pending bit, recomputes the pending priority and clears the flag.
- R7: During the acknowledge cycle, ack_word[15:8] holds the status register before the acknowledge. ack_word[7:0] holds the current priority after the acknowledge.
- R8: An acknowledge made while the exception flag is clear leaves the pending buffer and the current priority unchanged.
- R9: Once raised, irq_o and the exception flag stay set until an acknowledge, even when the current priority is written again.
- R10: Several operations in one cycle are applied in this order: acknowledge, current-priority write, then the pending merges (notification and set-pending), and then a fresh check against the result.
- R11: rd_data returns the selected context register: rd_sel 0 is the pending buffer, 1 the pending priority, 2 the current priority and 3 the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ntf_valid | input | 1 | One-cycle notification pulse |
| ntf_prio | input | 3 | Priority of the notification |
| spend_wr | input | 1 | Set-pending write strobe |
| spend_data | input | 8 | Set-pending priority byte |
| cur_wr | input | 1 | Current-priority write strobe |
| cur_wdata | input | 8 | New current priority |
| ack_req | input | 1 | Acknowledge operation |
| ack_word | output | 16 | Acknowledge result, valid while ack_req is high |
| rd_sel | input | 2 | Context register select |
| rd_data | output | 8 | Selected context register |
| irq_o | output | 1 | Level interrupt to the CPU |

## Verification
The hardest case to reach from the ports is an acknowledge that lands in the same cycle as a notification. It has to happen while an exception is outstanding and two or more priorities are pending, so that the retire, the merge and the fresh check all act on the same bitmap. The stimulus first opens the current priority, posts two priorities and lets the exception rise. It then fires the acknowledge and a notification together, once with a less favoured priority (no new interrupt) and once with a more favoured one (an immediate new interrupt). A table of single operations comes first and covers the equal-priority, out-of-range and repeated-acknowledge boundaries.

// File: rtl/prio_pkg.sv
package prio_pkg;
   typedef enum logic [1:0] {
      CTX_PBUF  = 2'd0,
      CTX_PPRIO = 2'd1,
      CTX_CUR   = 2'd2,
      CTX_STAT  = 2'd3
   } ctx_sel_e;
endpackage

// File: rtl/prio_pend_buf.sv
module prio_pend_buf #(
   parameter int NUM_PRIO = 8,
   parameter int REG_W    = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ntf_valid,
   input  logic [REG_W-1:0]    ntf_prio,
   input  logic                spend_wr,
   input  logic [REG_W-1:0]    spend_prio,
   input  logic                retire,
   output logic [NUM_PRIO-1:0] pbuf_o,
   output logic [REG_W-1:0]    pprio_o,
   output logic [REG_W-1:0]    pprio_next_o
);
   logic [NUM_PRIO-1:0] pbuf_q, pbuf_d, after_ack;
   logic [NUM_PRIO-1:0] ntf_mask, spend_mask, ret_mask;

   // priority p maps to bit NUM_PRIO-1-p; out-of-range values map to none
   function automatic logic [NUM_PRIO-1:0] prio_mask(input logic [REG_W-1:0] p);
      logic [NUM_PRIO-1:0] m;
      for (int i = 0; i < NUM_PRIO; i++)
         m[i] = (int'(p) == (NUM_PRIO - 1 - i));
      return m;
   endfunction

   // most favoured pending priority, all ones when empty
   function automatic logic [REG_W-1:0] first_pending(input logic [NUM_PRIO-1:0] b);
      logic [REG_W-1:0] r;
      r = '1;
      for (int i = NUM_PRIO - 1; i >= 0; i--)
         if (b[NUM_PRIO-1-i]) r = REG_W'(i);
      return r;
   endfunction

   assign ntf_mask   = ntf_valid ? prio_mask(ntf_prio) : '0;
   assign spend_mask = spend_wr ? prio_mask(spend_prio) : '0;
   assign ret_mask   = retire ? prio_mask(pprio_o) : '0;

   assign after_ack = pbuf_q & ~ret_mask;
   assign pbuf_d    = after_ack | ntf_mask | spend_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pbuf_q <= '0;
      else        pbuf_q <= pbuf_d;
   end

   assign pbuf_o       = pbuf_q;
   assign pprio_o      = first_pending(pbuf_q);
   assign pprio_next_o = first_pending(pbuf_d);
endmodule

// File: rtl/prio_ctx_ctrl.sv
module prio_ctx_ctrl #(
   parameter int REG_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ack_req,
   input  logic               cur_wr,
   input  logic [REG_W-1:0]   cur_wdata,
   input  logic               check_en,
   input  logic [REG_W-1:0]   pprio,
   input  logic [REG_W-1:0]   pprio_next,
   output logic               retire,
   output logic [REG_W-1:0]   cur_o,
   output logic [REG_W-1:0]   nsr_o,
   output logic               irq_o,
   output logic [2*REG_W-1:0] ack_word
);
   localparam int EXC_BIT = REG_W - 1;

   logic [REG_W-1:0] cur_q, cur_ack, cur_d, nsr_q, nsr_d;
   logic             irq_q, irq_d, fire;

   assign retire  = ack_req & nsr_q[EXC_BIT];
   assign cur_ack = retire ? pprio : cur_q;
   assign cur_d   = cur_wr ? cur_wdata : cur_ack;
   assign fire    = check_en && (pprio_next < cur_d);

   always_comb begin
      nsr_d = nsr_q;
      if (ack_req) nsr_d[EXC_BIT] = 1'b0;
      if (fire)    nsr_d[EXC_BIT] = 1'b1;
      irq_d = (irq_q & ~ack_req) | fire;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= '0;
         nsr_q <= '0;
         irq_q <= 1'b0;
      end else begin
         cur_q <= cur_d;
         nsr_q <= nsr_d;
         irq_q <= irq_d;
      end
   end

   assign cur_o    = cur_q;
   assign nsr_o    = nsr_q;
   assign irq_o    = irq_q;
   assign ack_word = {nsr_q, cur_ack};
endmodule

// File: rtl/prio_presenter.sv
module prio_presenter #(
   parameter int NUM_PRIO = 8,
   parameter int REG_W    = 8,
   localparam int PRIO_W  = $clog2(NUM_PRIO)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ntf_valid,
   input  logic [PRIO_W-1:0]  ntf_prio,
   input  logic               spend_wr,
   input  logic [REG_W-1:0]   spend_data,
   input  logic               cur_wr,
   input  logic [REG_W-1:0]   cur_wdata,
   input  logic               ack_req,
   output logic [2*REG_W-1:0] ack_word,
   input  logic [1:0]         rd_sel,
   output logic [REG_W-1:0]   rd_data,
   output logic               irq_o
);
   import prio_pkg::*;

   generate
      if (NUM_PRIO < 2 || NUM_PRIO > REG_W || PRIO_W > REG_W) begin : g_bad_cfg
         $error("prio_presenter: NUM_PRIO must lie in 2..REG_W");
      end
   endgenerate

   logic [NUM_PRIO-1:0] pbuf;
   logic [REG_W-1:0]    pprio, pprio_next, cur_q, nsr_q;
   logic                retire, check_en;

   assign check_en = ntf_valid | spend_wr | cur_wr;

   prio_pend_buf #(.NUM_PRIO(NUM_PRIO), .REG_W(REG_W)) u_pend (
      .clk          (clk),
      .rst_n        (rst_n),
      .ntf_valid    (ntf_valid),
      .ntf_prio     (REG_W'(ntf_prio)),
      .spend_wr     (spend_wr),
      .spend_prio   (spend_data),
      .retire       (retire),
      .pbuf_o       (pbuf),
      .pprio_o      (pprio),
      .pprio_next_o (pprio_next)
   );

   prio_ctx_ctrl #(.REG_W(REG_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .ack_req    (ack_req),
      .cur_wr     (cur_wr),
      .cur_wdata  (cur_wdata),
      .check_en   (check_en),
      .pprio      (pprio),
      .pprio_next (pprio_next),
      .retire     (retire),
      .cur_o      (cur_q),
      .nsr_o      (nsr_q),
      .irq_o      (irq_o),
      .ack_word   (ack_word)
   );

   always_comb begin
      case (ctx_sel_e'(rd_sel))
         CTX_PBUF:  rd_data = REG_W'(pbuf);
         CTX_PPRIO: rd_data = pprio;
         CTX_CUR:   rd_data = cur_q;
         default:   rd_data = nsr_q;
      endcase
   end
endmodule

// File: rtl/prio_presenter_chk.sv
module prio_presenter_chk #(
   parameter int NUM_PRIO = 8,
   parameter int REG_W    = 8,
   parameter int PRIO_W   = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                ntf_valid,
   input logic [PRIO_W-1:0]   ntf_prio,
   input logic                spend_wr,
   input logic                cur_wr,
   input logic                ack_req,
   input logic                irq_o,
   input logic [REG_W-1:0]    pprio,
   input logic [REG_W-1:0]    cur_q,
   input logic [REG_W-1:0]    nsr_q
);
   logic others;
   assign others = ntf_valid | spend_wr | cur_wr;

   assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o && !ack_req |=> irq_o);

   assert_ack_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ack_req && !others |=> !irq_o && !nsr_q[REG_W-1]);

   assert_ack_adopts_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ack_req && nsr_q[REG_W-1] && !cur_wr |=> cur_q == $past(pprio));

   assert_rise_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(others));

   assert_notify_seen_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ntf_valid && !ack_req |=> pprio <= REG_W'($past(ntf_prio)));

   assert_flag_matches_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == nsr_q[REG_W-1]);
endmodule

bind prio_presenter prio_presenter_chk #(
   .NUM_PRIO(NUM_PRIO), .REG_W(REG_W), .PRIO_W(PRIO_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ntf_valid (ntf_valid),
   .ntf_prio  (ntf_prio),
   .spend_wr  (spend_wr),
   .cur_wr    (cur_wr),
   .ack_req   (ack_req),
   .irq_o     (irq_o),
   .pprio     (pprio),
   .cur_q     (cur_q),
   .nsr_q     (nsr_q)
);

// File: tb/prio_presenter_test.sv
module prio_presenter_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ntf_valid = 1'b0;
   logic [2:0]  ntf_prio = '0;
   logic        spend_wr = 1'b0;
   logic [7:0]  spend_data = '0;
   logic        cur_wr = 1'b0;
   logic [7:0]  cur_wdata = '0;
   logic        ack_req = 1'b0;
   logic [15:0] ack_word;
   logic [1:0]  rd_sel = '0;
   logic [7:0]  rd_data;
   logic        irq_o;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   prio_presenter uut (
      .clk(clk), .rst_n(rst_n), .ntf_valid(ntf_valid), .ntf_prio(ntf_prio),
      .spend_wr(spend_wr), .spend_data(spend_data), .cur_wr(cur_wr),
      .cur_wdata(cur_wdata), .ack_req(ack_req), .ack_word(ack_word),
      .rd_sel(rd_sel), .rd_data(rd_data), .irq_o(irq_o)
   );

   // op codes: 0 notify, 1 set-pending, 2 current write, 3 acknowledge
   // fields: op, data, irq, pbuf, pprio, cur, status, ack word
   localparam logic [58:0] VECS [0:14] = '{
      {2'd0, 8'h05, 1'b0, 8'h04, 8'h05, 8'h00, 8'h00, 16'h0000},
      {2'd2, 8'hFF, 1'b1, 8'h04, 8'h05, 8'hFF, 8'h80, 16'h0000},
      {2'd0, 8'h02, 1'b1, 8'h24, 8'h02, 8'hFF, 8'h80, 16'h0000},
      {2'd3, 8'h00, 1'b0, 8'h04, 8'h05, 8'h02, 8'h00, 16'h8002},
      {2'd3, 8'h00, 1'b0, 8'h04, 8'h05, 8'h02, 8'h00, 16'h0002},
      {2'd1, 8'h09, 1'b0, 8'h04, 8'h05, 8'h02, 8'h00, 16'h0000},
      {2'd1, 8'h01, 1'b1, 8'h44, 8'h01, 8'h02, 8'h80, 16'h0000},
      {2'd2, 8'h00, 1'b1, 8'h44, 8'h01, 8'h00, 8'h80, 16'h0000},
      {2'd3, 8'h00, 1'b0, 8'h04, 8'h05, 8'h01, 8'h00, 16'h8001},
      {2'd2, 8'h05, 1'b0, 8'h04, 8'h05, 8'h05, 8'h00, 16'h0000},
      {2'd2, 8'h06, 1'b1, 8'h04, 8'h05, 8'h06, 8'h80, 16'h0000},
      {2'd3, 8'h00, 1'b0, 8'h00, 8'hFF, 8'h05, 8'h00, 16'h8005},
      {2'd2, 8'hFF, 1'b0, 8'h00, 8'hFF, 8'hFF, 8'h00, 16'h0000},
      {2'd0, 8'h07, 1'b1, 8'h01, 8'h07, 8'hFF, 8'h80, 16'h0000},
      {2'd1, 8'h00, 1'b1, 8'h81, 8'h00, 8'hFF, 8'h80, 16'h0000}
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] s, output logic [7:0] v);
      rd_sel = s;
      #1;
      v = rd_data;
   endtask

   task automatic check_regs(input string tag, input logic [7:0] pb, input logic [7:0] pp,
                             input logic [7:0] cu, input logic [7:0] st, input logic irq);
      logic [7:0] v;
      rd(2'd0, v); chk({tag, " R1 R11 pending buffer"}, 16'(v), 16'(pb));
      rd(2'd1, v); chk({tag, " R2 R11 pending priority"}, 16'(v), 16'(pp));
      rd(2'd2, v); chk({tag, " R6 R11 current priority"}, 16'(v), 16'(cu));
      rd(2'd3, v); chk({tag, " R4 R11 status"}, 16'(v), 16'(st));
      chk({tag, " R4 irq"}, 16'(irq_o), 16'(irq));
   endtask

   // drives one cycle of operations; returns ack_word sampled before the edge
   task automatic cycle(input logic n, input logic [2:0] np, input logic s, input logic [7:0] sd,
                        input logic c, input logic [7:0] cd, input logic a,
                        output logic [15:0] aw);
      @(negedge clk);
      ntf_valid = n; ntf_prio = np; spend_wr = s; spend_data = sd;
      cur_wr = c; cur_wdata = cd; ack_req = a;
      #2;
      aw = ack_word;
      @(posedge clk);
      #2;
      ntf_valid = 1'b0; spend_wr = 1'b0; cur_wr = 1'b0; ack_req = 1'b0;
   endtask

   initial begin
      logic [15:0] aw;
      repeat (3) @(negedge clk);
      // R3: reset values
      check_regs("reset R3", 8'h00, 8'hFF, 8'h00, 8'h00, 1'b0);
      rst_n = 1'b1;

      for (int i = 0; i < 15; i++) begin
         logic [1:0] op;
         logic [7:0] d;
         op = VECS[i][58:57];
         d  = VECS[i][56:49];
         cycle(op == 2'd0, d[2:0], op == 2'd1, d, op == 2'd2, d, op == 2'd3, aw);
         if (op == 2'd3) chk($sformatf("vec%0d R7 ack word", i), aw, VECS[i][15:0]);
         check_regs($sformatf("vec%0d", i), VECS[i][47:40], VECS[i][39:32],
                    VECS[i][31:24], VECS[i][23:16], VECS[i][48]);
      end

      // R10: ack with a less favoured notification: retire first, no new irq
      cycle(1'b1, 3'd3, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, aw);
      chk("R10 R7 ack word with notify", aw, 16'h8000);
      check_regs("R10 ack+notify3", 8'h11, 8'h03, 8'h00, 8'h00, 1'b0);
      cycle(1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 8'h04, 1'b0, aw);
      check_regs("R5 cur write 4", 8'h11, 8'h03, 8'h04, 8'h80, 1'b1);
      // R10: ack with a more favoured notification: fresh check fires at once
      cycle(1'b1, 3'd0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, aw);
      chk("R10 R7 ack word with notify", aw, 16'h8003);
      check_regs("R10 ack+notify0", 8'h81, 8'h00, 8'h03, 8'h80, 1'b1);
      // R9: writing the current priority does not drop the interrupt
      cycle(1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 8'h00, 1'b0, aw);
      check_regs("R9 hold", 8'h81, 8'h00, 8'h00, 8'h80, 1'b1);
      cycle(1'b0, 3'd0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, aw);
      chk("R7 ack word", aw, 16'h8000);
      check_regs("R6 ack", 8'h01, 8'h07, 8'h00, 8'h00, 1'b0);
      // R8: acknowledge with no exception changes nothing
      cycle(1'b0, 3'd0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, aw);
      chk("R8 R7 ack word idle", aw, 16'h0000);
      check_regs("R8 idle ack", 8'h01, 8'h07, 8'h00, 8'h00, 1'b0);
      // R5: re-posting a pending priority still checks; then a cur write checks
      cycle(1'b1, 3'd7, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, aw);
      check_regs("R5 repost", 8'h01, 8'h07, 8'h00, 8'h00, 1'b0);
      cycle(1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 8'h08, 1'b0, aw);
      check_regs("R5 cur write 8", 8'h01, 8'h07, 8'h08, 8'h80, 1'b1);
      // R3: asynchronous reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      #2;
      check_regs("mid reset R3", 8'h00, 8'hFF, 8'h00, 8'h00, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog R3 actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule